// File: doc/BRIEF.md
# Set Replacement Controller

This block holds the replacement bookkeeping for every set of an N-way set-associative cache and names the way to evict when the surrounding cache controller asks. It reacts to three events. A fill places a new block in a given way, and that block becomes the most recently used one. A hit promotes the way that hit. A victim request names a set and receives, one cycle later, the way that should make room. The controller also records which ways of each set hold a block. A way that is still empty always wins over any occupied way.

The `POLICY` parameter selects the rule at elaboration: exact least-recently-used, not-most-recently-used, binary-tree pseudo-LRU, first-in-first-out, or pseudo-random. A fill may carry a no-reuse hint. Such a fill is dropped entirely, so neither the occupancy nor the ordering of its set moves. Tag and data storage, and the miss handling after the victim is known, belong to the surrounding cache.

Top module: `repl_ctrl`

## Requirements
- R1: After reset every way of every set is empty and `vic_valid` is low. The first victim request to any set returns way 0.
- R2: `vic_valid` is high in exactly the cycle after a cycle with `vic_req` high. `vic_way` is taken from the state as it stood before any fill or hit applied in the request cycle.
- R3: If the requested set holds an empty way, the victim is the lowest-numbered empty way, under every policy.
- R4: Exact LRU (`POL_LRU`): with all ways occupied, the victim is the way whose latest fill or hit is oldest. With two ways, the state is one bit per set.
- R5: Not-MRU (`POL_NMRU`): with all ways occupied, the victim is (most recently filled or hit way + 1) mod WAYS. It is never the most recently used way.
- R6: Tree pseudo-LRU (`POL_TREE`, WAYS a power of two): each set has WAYS-1 decision bits. A fill or hit sets each bit on the path to the accessed way so that it points at the other half. The victim is found by following the bits from the root.
- R7: FIFO (`POL_FIFO`): with all ways occupied, the victim is the way whose latest fill is oldest. Hits change nothing.
- R8: Random (`POL_RAND`): with all ways occupied, the victim is a free-running 16-bit LFSR value reduced modulo WAYS. It is always below WAYS and varies over time.
- R9: A fill with `fill_noreuse` high leaves both the occupancy and the replacement state of its set unchanged.
- R10: When a fill and a hit reach the same set in one cycle, the fill is applied first and the hit second, so the hit way ends up most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_en | input | 1 | A block is being placed in `fill_way` of `fill_set` |
| fill_set | input | $clog2(SETS) | Set receiving the fill |
| fill_way | input | $clog2(WAYS) | Way receiving the fill |
| fill_noreuse | input | 1 | Fill predicted to have no reuse; the fill is dropped |
| hit_en | input | 1 | A lookup hit a resident way |
| hit_set | input | $clog2(SETS) | Set of the hit |
| hit_way | input | $clog2(WAYS) | Way that hit |
| vic_req | input | 1 | Victim wanted for `vic_set` |
| vic_set | input | $clog2(SETS) | Set whose victim is asked for |
| vic_way | output | $clog2(WAYS) | Chosen victim way, valid with `vic_valid` |
| vic_valid | output | 1 | `vic_way` answers the request of the previous cycle |

## Verification
The bench runs five copies side by side, one per policy, all driven by the same stream. That stream mixes random fills, hits and bypassed fills on a few sets with directed sequences.

One directed case gives a fill and a hit to the same set in the same cycle. A design that applies them in the wrong order leaves the filled way as most recently used, and the not-MRU copy then names the wrong victim. A bypassed fill to a full set catches a design that lets the hint still promote the way, which shifts the LRU victim. Random hits under FIFO expose a design that promotes on hits. Requests to sets that are only partly filled expose any policy that skips the empty-way priority. Requests issued together with a fill to the same set show whether the answer was wrongly taken from the updated state.

// File: rtl/repl_pkg.sv
package repl_pkg;

   typedef enum int {
      POL_LRU  = 0,
      POL_NMRU = 1,
      POL_TREE = 2,
      POL_FIFO = 3,
      POL_RAND = 4
   } policy_e;

   // How the per-set state is organised
   typedef enum int {
      K_TREE = 0,   // WAYS-1 decision bits
      K_RANK = 1,   // one age field per way
      K_PTR  = 2,   // most recently used way
      K_NONE = 3    // no per-set state
   } state_kind_e;

   function automatic state_kind_e kind_of(policy_e p, int ways);
      case (p)
         POL_LRU:  return (ways == 2) ? K_TREE : K_RANK;
         POL_TREE: return K_TREE;
         POL_FIFO: return K_RANK;
         POL_NMRU: return K_PTR;
         default:  return K_NONE;
      endcase
   endfunction

   function automatic int state_bits(policy_e p, int ways);
      int ww;
      ww = (ways > 1) ? $clog2(ways) : 1;
      case (kind_of(p, ways))
         K_TREE:  return ways - 1;
         K_RANK:  return ways * ww;
         K_PTR:   return ww;
         default: return 1;
      endcase
   endfunction

   function automatic bit hit_moves(policy_e p);
      return (p != POL_FIFO) && (p != POL_RAND);
   endfunction

endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
   parameter int           W    = 16,
   parameter logic [W-1:0] TAPS = 16'hB400,
   parameter logic [W-1:0] SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] rnd
);
   logic [W-1:0] lfsr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lfsr_q <= SEED;
      else if (lfsr_q[0]) lfsr_q <= (lfsr_q >> 1) ^ TAPS;
      else                lfsr_q <= lfsr_q >> 1;
   end

   assign rnd = lfsr_q;
endmodule

// File: rtl/repl_set_update.sv
module repl_set_update
   import repl_pkg::*;
#(
   parameter int      WAYS   = 4,
   parameter policy_e POLICY = POL_LRU,
   parameter int      SBW    = 8
) (
   input  logic [SBW-1:0]            st_i,
   input  logic                      fill_do,
   input  logic [$clog2(WAYS)-1:0]   fill_way,
   input  logic                      hit_do,
   input  logic [$clog2(WAYS)-1:0]   hit_way,
   output logic [SBW-1:0]            st_o
);
   localparam int          WW   = $clog2(WAYS);
   localparam state_kind_e KIND = kind_of(POLICY, WAYS);
   localparam bit          HITS = hit_moves(POLICY);

   logic [SBW-1:0] st_mid;

   generate
      if (KIND == K_TREE) begin : g_tree
         function automatic logic [SBW-1:0] touch(logic [SBW-1:0] s, logic [WW-1:0] w);
            int node;
            node = 1;
            for (int l = WW - 1; l >= 0; l--) begin
               s[node-1] = ~w[l];
               node      = 2 * node + int'(w[l]);
            end
            return s;
         endfunction
         always_comb begin
            st_mid = fill_do ? touch(st_i, fill_way) : st_i;
            st_o   = (hit_do && HITS) ? touch(st_mid, hit_way) : st_mid;
         end
      end else if (KIND == K_RANK) begin : g_rank
         function automatic logic [SBW-1:0] touch(logic [SBW-1:0] s, logic [WW-1:0] w);
            logic [WW-1:0] age_w;
            age_w = s[int'(w)*WW +: WW];
            for (int i = 0; i < WAYS; i++) begin
               if (s[i*WW +: WW] < age_w) s[i*WW +: WW] = s[i*WW +: WW] + 1'b1;
            end
            s[int'(w)*WW +: WW] = '0;
            return s;
         endfunction
         always_comb begin
            st_mid = fill_do ? touch(st_i, fill_way) : st_i;
            st_o   = (hit_do && HITS) ? touch(st_mid, hit_way) : st_mid;
         end
      end else if (KIND == K_PTR) begin : g_ptr
         always_comb begin
            st_mid = fill_do ? SBW'(fill_way) : st_i;
            st_o   = (hit_do && HITS) ? SBW'(hit_way) : st_mid;
         end
      end else begin : g_none
         always_comb begin
            st_mid = st_i;
            st_o   = st_mid;
         end
      end
   endgenerate
endmodule

// File: rtl/repl_victim_pick.sv
module repl_victim_pick
   import repl_pkg::*;
#(
   parameter int      WAYS   = 4,
   parameter policy_e POLICY = POL_LRU,
   parameter int      SBW    = 8,
   parameter int      RW     = 16
) (
   input  logic [SBW-1:0]          st_i,
   input  logic [WAYS-1:0]         occ_i,
   input  logic [RW-1:0]           rnd_i,
   output logic [$clog2(WAYS)-1:0] way_o
);
   localparam int          WW   = $clog2(WAYS);
   localparam state_kind_e KIND = kind_of(POLICY, WAYS);

   logic [WW-1:0] pol_way;
   logic [WW-1:0] empty_way;
   logic          any_empty;

   always_comb begin
      any_empty = 1'b0;
      empty_way = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (!occ_i[i]) begin
            any_empty = 1'b1;
            empty_way = WW'(i);
         end
      end
   end

   generate
      if (KIND == K_TREE) begin : g_tree
         always_comb begin
            int node;
            node    = 1;
            pol_way = '0;
            for (int l = WW - 1; l >= 0; l--) begin
               pol_way[l] = st_i[node-1];
               node       = 2 * node + int'(st_i[node-1]);
            end
         end
      end else if (KIND == K_RANK) begin : g_rank
         always_comb begin
            pol_way = '0;
            for (int i = 0; i < WAYS; i++) begin
               if (st_i[i*WW +: WW] == WW'(WAYS - 1)) pol_way = WW'(i);
            end
         end
      end else if (KIND == K_PTR) begin : g_ptr
         always_comb begin
            if (int'(st_i[WW-1:0]) == WAYS - 1) pol_way = '0;
            else                                pol_way = st_i[WW-1:0] + 1'b1;
         end
      end else begin : g_rand
         always_comb pol_way = WW'(rnd_i % RW'(WAYS));
      end
   endgenerate

   assign way_o = any_empty ? empty_way : pol_way;
endmodule

// File: rtl/repl_ctrl.sv
module repl_ctrl
   import repl_pkg::*;
#(
   parameter int      WAYS   = 4,
   parameter int      SETS   = 16,
   parameter policy_e POLICY = POL_LRU,
   parameter int      RW     = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fill_en,
   input  logic [$clog2(SETS)-1:0]   fill_set,
   input  logic [$clog2(WAYS)-1:0]   fill_way,
   input  logic                      fill_noreuse,
   input  logic                      hit_en,
   input  logic [$clog2(SETS)-1:0]   hit_set,
   input  logic [$clog2(WAYS)-1:0]   hit_way,
   input  logic                      vic_req,
   input  logic [$clog2(SETS)-1:0]   vic_set,
   output logic [$clog2(WAYS)-1:0]   vic_way,
   output logic                      vic_valid
);
   localparam int          WW   = $clog2(WAYS);
   localparam int          SW   = $clog2(SETS);
   localparam int          SBW  = state_bits(POLICY, WAYS);
   localparam state_kind_e KIND = kind_of(POLICY, WAYS);

   // Elaboration checks
   generate
      if (WAYS < 2) begin : g_bad_ways
         $error("repl_ctrl: WAYS must be at least 2");
      end
      if (SETS < 2 || SETS != (1 << SW)) begin : g_bad_sets
         $error("repl_ctrl: SETS must be a power of two, at least 2");
      end
      if (KIND == K_TREE && WAYS != (1 << WW)) begin : g_bad_tree
         $error("repl_ctrl: tree policy needs a power-of-two WAYS");
      end
   endgenerate

   function automatic logic [SBW-1:0] init_state();
      logic [SBW-1:0] s;
      s = '0;
      if (KIND == K_RANK) begin
         for (int i = 0; i < WAYS; i++) s[i*WW +: WW] = WW'(i);
      end
      return s;
   endfunction

   localparam logic [SBW-1:0] ST_INIT = init_state();

   logic [SETS-1:0][WAYS-1:0] valid_q;
   logic [SETS-1:0][SBW-1:0]  state_q;
   logic [RW-1:0]             rnd;
   logic                      fill_apply;
   logic                      same_set;
   logic [SBW-1:0]            st_fill_nxt;
   logic [SBW-1:0]            st_hit_nxt;
   logic [WW-1:0]             pick;

   assign fill_apply = fill_en && !fill_noreuse;
   assign same_set   = fill_apply && hit_en && (hit_set == fill_set);

   repl_lfsr #(.W(RW)) lfsr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (rnd)
   );

   // Fill path, folding in a same-set hit after the fill
   repl_set_update #(.WAYS(WAYS), .POLICY(POLICY), .SBW(SBW)) upd_fill_i (
      .st_i     (state_q[fill_set]),
      .fill_do  (fill_apply),
      .fill_way (fill_way),
      .hit_do   (same_set),
      .hit_way  (hit_way),
      .st_o     (st_fill_nxt)
   );

   // Hit path for a set that sees no fill this cycle
   repl_set_update #(.WAYS(WAYS), .POLICY(POLICY), .SBW(SBW)) upd_hit_i (
      .st_i     (state_q[hit_set]),
      .fill_do  (1'b0),
      .fill_way (fill_way),
      .hit_do   (hit_en),
      .hit_way  (hit_way),
      .st_o     (st_hit_nxt)
   );

   repl_victim_pick #(.WAYS(WAYS), .POLICY(POLICY), .SBW(SBW), .RW(RW)) pick_i (
      .st_i  (state_q[vic_set]),
      .occ_i (valid_q[vic_set]),
      .rnd_i (rnd),
      .way_o (pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int s = 0; s < SETS; s++) state_q[s] <= ST_INIT;
      end else begin
         if (hit_en && !same_set) state_q[hit_set] <= st_hit_nxt;
         if (fill_apply) begin
            state_q[fill_set]           <= st_fill_nxt;
            valid_q[fill_set][fill_way] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vic_valid <= 1'b0;
         vic_way   <= '0;
      end else begin
         vic_valid <= vic_req;
         if (vic_req) vic_way <= pick;
      end
   end
endmodule

// File: rtl/repl_ctrl_chk.sv
module repl_ctrl_chk
   import repl_pkg::*;
#(
   parameter int      WAYS   = 4,
   parameter int      SETS   = 16,
   parameter policy_e POLICY = POL_LRU,
   parameter int      SBW    = 8
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             fill_en,
   input logic [$clog2(SETS)-1:0]          fill_set,
   input logic                             fill_noreuse,
   input logic                             hit_en,
   input logic [$clog2(SETS)-1:0]          hit_set,
   input logic                             vic_req,
   input logic [$clog2(SETS)-1:0]          vic_set,
   input logic [$clog2(WAYS)-1:0]          vic_way,
   input logic                             vic_valid,
   input logic [SETS-1:0][WAYS-1:0]        valid_q,
   input logic [SETS-1:0][SBW-1:0]         state_q
);
   localparam int WW = $clog2(WAYS);

   a_r2_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
      vic_req |=> vic_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !vic_req |=> !vic_valid);

   a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> (int'(vic_way) < WAYS));

   a_r3_way0_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_req && !valid_q[vic_set][0]) |=> (vic_way == '0));

   a_r9_bypass_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && fill_noreuse && !(hit_en && hit_set == fill_set))
      |=> (valid_q[$past(fill_set)] == $past(valid_q[fill_set]))
       && (state_q[$past(fill_set)] == $past(state_q[fill_set])));

   generate
      if (POLICY == POL_NMRU) begin : g_nmru
         a_r5_not_mru: assert property (@(posedge clk) disable iff (!rst_n)
            (vic_req && (&valid_q[vic_set]))
            |=> (vic_way != $past(state_q[vic_set][WW-1:0])));
      end
      if (POLICY == POL_FIFO) begin : g_fifo
         a_r7_hit_inert: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_en && !fill_en)
            |=> (state_q[$past(hit_set)] == $past(state_q[hit_set])));
      end
   endgenerate
endmodule

bind repl_ctrl repl_ctrl_chk #(
   .WAYS(WAYS), .SETS(SETS), .POLICY(POLICY), .SBW(SBW)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .fill_en      (fill_en),
   .fill_set     (fill_set),
   .fill_noreuse (fill_noreuse),
   .hit_en       (hit_en),
   .hit_set      (hit_set),
   .vic_req      (vic_req),
   .vic_set      (vic_set),
   .vic_way      (vic_way),
   .vic_valid    (vic_valid),
   .valid_q      (valid_q),
   .state_q      (state_q)
);

// File: tb/repl_ctrl_tb_top.sv
module repl_ctrl_tb_top;
   import repl_pkg::*;

   localparam int CLK_P = 10;
   localparam int NW    = 4;
   localparam int NS    = 8;
   localparam int NP    = 5;   // 0 LRU, 1 NMRU, 2 TREE, 3 FIFO, 4 RAND

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fill_en = 0, fill_noreuse = 0, hit_en = 0, vic_req = 0;
   logic [2:0] fill_set = 0, hit_set = 0, vic_set = 0;
   logic [1:0] fill_way = 0, hit_way = 0;
   logic [1:0] vw [NP];
   logic       vv [NP];

   always #(CLK_P/2) clk = ~clk;

   repl_ctrl #(.WAYS(NW), .SETS(NS), .POLICY(POL_LRU)) dut_i (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
      .fill_noreuse(fill_noreuse), .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
      .vic_req(vic_req), .vic_set(vic_set), .vic_way(vw[0]), .vic_valid(vv[0]));
   repl_ctrl #(.WAYS(NW), .SETS(NS), .POLICY(POL_NMRU)) dut_nmru_i (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
      .fill_noreuse(fill_noreuse), .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
      .vic_req(vic_req), .vic_set(vic_set), .vic_way(vw[1]), .vic_valid(vv[1]));
   repl_ctrl #(.WAYS(NW), .SETS(NS), .POLICY(POL_TREE)) dut_tree_i (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
      .fill_noreuse(fill_noreuse), .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
      .vic_req(vic_req), .vic_set(vic_set), .vic_way(vw[2]), .vic_valid(vv[2]));
   repl_ctrl #(.WAYS(NW), .SETS(NS), .POLICY(POL_FIFO)) dut_fifo_i (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
      .fill_noreuse(fill_noreuse), .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
      .vic_req(vic_req), .vic_set(vic_set), .vic_way(vw[3]), .vic_valid(vv[3]));
   repl_ctrl #(.WAYS(NW), .SETS(NS), .POLICY(POL_RAND)) dut_rand_i (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
      .fill_noreuse(fill_noreuse), .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
      .vic_req(vic_req), .vic_set(vic_set), .vic_way(vw[4]), .vic_valid(vv[4]));

   // Reference model, shared by all policies
   bit    mv    [NS][NW];
   int    t_acc [NS][NW];
   int    t_fil [NS][NW];
   int    mru   [NS];
   bit    tb    [NS][3];
   int    now;
   int    checks = 0;
   int    errors = 0;
   bit    pend_req = 0;
   int    pend_exp [NP];
   string pend_tag;
   bit    pend_full = 0;
   bit    rand_seen [NW];

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic bit has_empty(int s);
      for (int w = 0; w < NW; w++) if (!mv[s][w]) return 1;
      return 0;
   endfunction

   function automatic int mvict(int p, int s);
      int best;
      for (int w = 0; w < NW; w++) if (!mv[s][w]) return w;
      best = 0;
      case (p)
         0: for (int w = 1; w < NW; w++) if (t_acc[s][w] < t_acc[s][best]) best = w;
         1: best = (mru[s] + 1) % NW;
         2: best = !tb[s][0] ? (tb[s][1] ? 1 : 0) : (tb[s][2] ? 3 : 2);
         3: for (int w = 1; w < NW; w++) if (t_fil[s][w] < t_fil[s][best]) best = w;
         default: best = -1;
      endcase
      return best;
   endfunction

   function automatic void tree_touch(int s, int w);
      tb[s][0] = (w < 2);
      if (w < 2) tb[s][1] = (w == 0);
      else       tb[s][2] = (w == 2);
   endfunction

   function automatic string auto_tag(int p, int s);
      if (has_empty(s)) return "R3";
      case (p)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         3: return "R7";
         default: return "R8";
      endcase
   endfunction

   // One cycle: check the previous answer, drive new inputs, advance the model
   task automatic step(bit fe, int fs, int fw, bit fn, bit he, int hs, int hw,
                       bit vr, int vs, string tag);
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
         chk(vv[p] == pend_req, "R2", $sformatf("vic_valid p%0d", p), int'(vv[p]), int'(pend_req));
         if (pend_req) begin
            if (pend_exp[p] < 0) begin
               chk(int'(vw[p]) < NW, "R8", "random victim range", int'(vw[p]), NW - 1);
               if (pend_full) rand_seen[vw[p]] = 1;
            end else begin
               chk(int'(vw[p]) == pend_exp[p], (pend_tag != "") ? pend_tag : auto_tag(p, 0),
                   $sformatf("victim p%0d", p), int'(vw[p]), pend_exp[p]);
            end
         end
      end
      fill_en = fe; fill_set = 3'(fs); fill_way = 2'(fw); fill_noreuse = fn;
      hit_en = he; hit_set = 3'(hs); hit_way = 2'(hw);
      vic_req = vr; vic_set = 3'(vs);
      pend_req  = vr;
      pend_full = !has_empty(vs);
      pend_tag  = tag;
      if (tag == "") pend_tag = has_empty(vs) ? "R3" : "";
      for (int p = 0; p < NP; p++) pend_exp[p] = mvict(p, vs);
      if (pend_tag == "" && vr) pend_tag = "";
      now++;
      if (fe && !fn) begin
         mv[fs][fw] = 1; t_acc[fs][fw] = 2 * now; t_fil[fs][fw] = 2 * now;
         mru[fs] = fw; tree_touch(fs, fw);
      end
      if (he) begin
         t_acc[hs][hw] = 2 * now + 1; mru[hs] = hw; tree_touch(hs, hw);
      end
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      int seed_dummy;
      int distinct;
      seed_dummy = $urandom(32'd1234);
      now = 0;
      for (int s = 0; s < NS; s++) begin
         mru[s] = 0;
         for (int w = 0; w < NW; w++) begin mv[s][w] = 0; t_acc[s][w] = 0; t_fil[s][w] = 0; end
         for (int b = 0; b < 3; b++) tb[s][b] = 0;
      end
      for (int w = 0; w < NW; w++) rand_seen[w] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      for (int p = 0; p < NP; p++) chk(vv[p] == 1'b0, "R1", "vic_valid after reset", int'(vv[p]), 0);
      step(0, 0, 0, 0, 0, 0, 0, 1, 5, "R1");
      idle();

      // R9: bypassed fill on an empty and on a full set
      step(1, 7, 0, 1, 0, 0, 0, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 0, 1, 7, "R9");
      for (int w = 0; w < NW; w++) step(1, 7, w, 0, 0, 0, 0, 0, 0, "");
      step(1, 7, 0, 1, 0, 0, 0, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 0, 1, 7, "R9");

      // R10: simultaneous fill and hit on the same set
      for (int w = 0; w < NW; w++) step(1, 6, w, 0, 0, 0, 0, 0, 0, "");
      step(1, 6, 0, 0, 1, 6, 1, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 0, 1, 6, "R10");
      step(0, 0, 0, 0, 1, 6, 2, 0, 0, "");
      step(0, 0, 0, 0, 1, 6, 3, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 0, 1, 6, "R10");

      // R2: request in the same cycle as a fill to that set sees old state
      step(1, 5, 2, 0, 0, 0, 0, 1, 5, "R2");
      idle();

      // Random mix on sets 0..3
      for (int i = 0; i < 3000; i++) begin
         bit fe, fn, he, vr;
         int fs, fw, hs, hw, vs;
         fe = ($urandom % 4) == 0;
         fn = ($urandom % 5) == 0;
         fs = $urandom % 4;
         fw = $urandom % NW;
         hs = $urandom % 4;
         hw = $urandom % NW;
         he = (($urandom % 2) == 0) && mv[hs][hw];
         vr = ($urandom % 3) == 0;
         vs = $urandom % 4;
         step(fe, fs, fw, fn, he, hs, hw, vr, vs, "");
      end
      idle();

      distinct = 0;
      for (int w = 0; w < NW; w++) distinct += int'(rand_seen[w]);
      chk(distinct > 1, "R8", "distinct random victims", distinct, 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule